// File: doc/BRIEF.md
# Vector First-Negative-Lane Index Unit

This execution unit serves a 256-bit SIMD datapath. It splits the source vector into two 128-bit halves and handles each half on its own. In each half it finds the lowest-numbered lane whose element is negative when read as a signed integer. It writes that lane number into one chosen lane of the matching half of the destination. Every other destination lane passes through from the old destination value supplied with the operation. Lanes are either 8 or 16 bits wide.

The destination lane is chosen in one of two ways. The register form takes it from a third vector operand, reading the lowest lane of each half separately. The immediate form takes it from a 5-bit immediate, and the same lane position is used in both halves. An operation arrives as a single valid-qualified beat. That beat carries the 17-bit opcode field, the source vector, the selector vector, the old destination and the immediate. The merged result is registered and comes out one cycle later with its own valid strobe.

Top module: `vneg_index_unit`

## Requirements
- R1: In each 128-bit half, the index written is the smallest lane number, counted from 0 inside that half, whose lane MSB (the sign bit) is 1. Lanes are 8-bit for byte operations and 16-bit for halfword operations, and the two halves do not affect each other.
- R2: A half in which no lane has its sign bit set produces the per-half lane count as its index: 16 for byte operations, 8 for halfword operations.
- R3: In the register form, the low-half target lane comes from selector bits [3:0] for bytes or [2:0] for halfwords. The high-half target lane comes from selector bits [131:128] for bytes or [130:128] for halfwords, and it addresses a lane in the upper half. All other selector bits are ignored.
- R4: In the immediate form, the target lane is the immediate modulo the per-half lane count: imm[3:0] for bytes, imm[2:0] for halfwords. It selects the same relative lane in both halves, and immediates from 16 to 31 wrap around.
- R5: Each half changes at most one destination lane. Every other bit of the result equals the old destination.
- R6: Opcode bits [16:5] are 0111_01010010 for the register form and 0111_01101001 for the immediate form. Bits [4:0] are 1011s for the register form and 1010s for the immediate form, where s=0 selects bytes and s=1 selects halfwords.
- R7: The index is written zero-extended to fill the whole target lane.
- R8: The result and out_valid appear on the clock edge after an accepted beat. out_valid is high for exactly one cycle per accepted beat, and it is low while reset is asserted and afterwards until a beat is accepted.
- R9: An opcode outside the four encodings returns the old destination unchanged, and out_valid is still asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation beat present |
| in_opcode | input | 17 | Opcode field (major and subfield bits) |
| in_src | input | 256 | Vector scanned for negative lanes |
| in_sel | input | 256 | Selector vector for the register form |
| in_old | input | 256 | Previous destination contents |
| in_imm | input | 5 | Lane selector for the immediate form |
| out_valid | output | 1 | Result strobe, one cycle per operation |
| out_result | output | 256 | Merged destination vector |

## Verification
For all four encodings, the bench sweeps the position of the first negative lane across every lane of the low half, plus a "none negative" case, while the high half gets a different position. This tells apart an index computed per half from one computed over the whole vector, and it also separates the lowest match from the highest. Lanes below the negative lane have their sign bit cleared, and lanes above it carry random values that may be negative. This exposes a scan that accepts a later lane instead of the first. Each target lane, and every immediate from 0 to 31, is tried with random set bits above the mask in the selector. This separates correct masking and wrap-around from use of the raw field. Neighbouring unused opcodes and back-to-back beats check the pass-through path and the one-cycle timing.

// File: rtl/vni_pkg.sv
package vni_pkg;

  localparam int OPC_W = 17;

  // Major fields (opcode bits [16:5]) and subfield prefixes (bits [4:1]).
  localparam logic [11:0] MAJ_REG = 12'b0111_0101_0010;
  localparam logic [11:0] MAJ_IMM = 12'b0111_0110_1001;
  localparam logic [3:0]  SUB_REG = 4'b1011;
  localparam logic [3:0]  SUB_IMM = 4'b1010;

  typedef enum logic [1:0] {
    FORM_NONE = 2'd0,
    FORM_REG  = 2'd1,
    FORM_IMM  = 2'd2
  } form_e;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_HALF = 1'b1
  } size_e;

  typedef struct packed {
    form_e form;
    size_e size;
  } opdec_t;

endpackage

// File: rtl/vni_rst_sync.sv
module vni_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;

endmodule

// File: rtl/vni_decode.sv
module vni_decode
  import vni_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output opdec_t           dec
);

  logic [11:0] major;
  logic [3:0]  sub_pfx;

  assign major   = opcode[16:5];
  assign sub_pfx = opcode[4:1];

  always_comb begin
    dec.form = FORM_NONE;
    dec.size = opcode[0] ? SZ_HALF : SZ_BYTE;
    if (major == MAJ_REG && sub_pfx == SUB_REG) begin
      dec.form = FORM_REG;
    end else if (major == MAJ_IMM && sub_pfx == SUB_IMM) begin
      dec.form = FORM_IMM;
    end
  end

endmodule

// File: rtl/vni_half_scan.sv
module vni_half_scan #(
  parameter int HALF_W = 128,
  parameter int IDX_W  = 5
) (
  input  logic [HALF_W-1:0] half_src,
  output logic [IDX_W-1:0]  first_b,
  output logic [IDX_W-1:0]  first_h
);

  localparam int B_LANES = HALF_W / 8;
  localparam int H_LANES = HALF_W / 16;

  logic [B_LANES-1:0] neg_b;
  logic [H_LANES-1:0] neg_h;

  for (genvar g = 0; g < B_LANES; g++) begin : g_sign_b
    assign neg_b[g] = half_src[8*g + 7];
  end

  for (genvar g = 0; g < H_LANES; g++) begin : g_sign_h
    assign neg_h[g] = half_src[16*g + 15];
  end

  // Priority search: walking downward lets the lowest match win.
  always_comb begin
    first_b = IDX_W'(B_LANES);
    for (int i = B_LANES - 1; i >= 0; i--) begin
      if (neg_b[i]) first_b = IDX_W'(i);
    end
  end

  always_comb begin
    first_h = IDX_W'(H_LANES);
    for (int i = H_LANES - 1; i >= 0; i--) begin
      if (neg_h[i]) first_h = IDX_W'(i);
    end
  end

endmodule

// File: rtl/vni_half_merge.sv
module vni_half_merge
  import vni_pkg::*;
#(
  parameter int HALF_W = 128,
  parameter int IDX_W  = 5,
  parameter int SLOT_W = 4
) (
  input  logic [HALF_W-1:0] old_half,
  input  logic              wr_en,
  input  size_e             size,
  input  logic [SLOT_W-1:0] slot,
  input  logic [IDX_W-1:0]  idx,
  output logic [HALF_W-1:0] new_half
);

  always_comb begin
    new_half = old_half;
    if (wr_en) begin
      if (size == SZ_BYTE) begin
        new_half[int'(slot)*8 +: 8] = 8'(idx);
      end else begin
        new_half[int'(slot[SLOT_W-2:0])*16 +: 16] = 16'(idx);
      end
    end
  end

endmodule

// File: rtl/vneg_index_unit.sv
module vneg_index_unit
  import vni_pkg::*;
#(
  parameter int VEC_W  = 256,
  parameter int HALF_W = 128,
  parameter int IMM_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [16:0]      in_opcode,
  input  logic [VEC_W-1:0] in_src,
  input  logic [VEC_W-1:0] in_sel,
  input  logic [VEC_W-1:0] in_old,
  input  logic [IMM_W-1:0] in_imm,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_result
);

  localparam int NUM_HALVES = VEC_W / HALF_W;
  localparam int B_LANES    = HALF_W / 8;
  localparam int SLOT_W     = $clog2(B_LANES);
  localparam int IDX_W      = SLOT_W + 1;

  logic             rst_n_sync;
  opdec_t           dec;
  logic [VEC_W-1:0] nxt_result;
  logic [VEC_W-1:0] res_q;
  logic             vld_q;
  logic             unused_imm;

  vni_rst_sync u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  vni_decode u_decode (
    .opcode (in_opcode),
    .dec    (dec)
  );

  assign unused_imm = ^in_imm[IMM_W-1:SLOT_W];

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [IDX_W-1:0]  first_b;
    logic [IDX_W-1:0]  first_h;
    logic [IDX_W-1:0]  idx;
    logic [SLOT_W-1:0] raw_slot;
    logic [SLOT_W-1:0] slot;
    logic              unused_sel;

    assign unused_sel = ^in_sel[h*HALF_W + SLOT_W +: HALF_W - SLOT_W];

    vni_half_scan #(
      .HALF_W (HALF_W),
      .IDX_W  (IDX_W)
    ) u_scan (
      .half_src (in_src[h*HALF_W +: HALF_W]),
      .first_b  (first_b),
      .first_h  (first_h)
    );

    // Target lane: selector lane at the base of this half, or the immediate.
    always_comb begin
      raw_slot = (dec.form == FORM_REG) ? in_sel[h*HALF_W +: SLOT_W]
                                        : in_imm[SLOT_W-1:0];
      slot     = (dec.size == SZ_HALF) ? {1'b0, raw_slot[SLOT_W-2:0]}
                                       : raw_slot;
      idx      = (dec.size == SZ_BYTE) ? first_b : first_h;
    end

    vni_half_merge #(
      .HALF_W (HALF_W),
      .IDX_W  (IDX_W),
      .SLOT_W (SLOT_W)
    ) u_merge (
      .old_half (in_old[h*HALF_W +: HALF_W]),
      .wr_en    (dec.form != FORM_NONE),
      .size     (dec.size),
      .slot     (slot),
      .idx      (idx),
      .new_half (nxt_result[h*HALF_W +: HALF_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      res_q <= nxt_result;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;

endmodule

// File: rtl/vni_unit_chk.sv
module vni_unit_chk
  import vni_pkg::*;
#(
  parameter int VEC_W  = 256,
  parameter int HALF_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [16:0]      in_opcode,
  input logic [VEC_W-1:0] in_old,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_result
);

  localparam int NUM_HALVES = VEC_W / HALF_W;
  localparam int H_LANES    = HALF_W / 16;
  localparam int NUM_HW     = VEC_W / 16;

  logic             known_op;
  logic [VEC_W-1:0] old_q;
  logic [NUM_HW-1:0] hw_diff;

  assign known_op = (in_opcode[16:5] == MAJ_REG && in_opcode[4:1] == SUB_REG) ||
                    (in_opcode[16:5] == MAJ_IMM && in_opcode[4:1] == SUB_IMM);

  always_ff @(posedge clk) begin
    if (in_valid) old_q <= in_old;
  end

  always_comb begin
    for (int k = 0; k < NUM_HW; k++) begin
      hw_diff[k] = (out_result[16*k +: 16] != old_q[16*k +: 16]);
    end
  end

  a_r8_accept_gives_valid: assert property (
    @(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);

  a_r8_idle_no_valid: assert property (
    @(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);

  a_r9_unknown_keeps_old: assert property (
    @(posedge clk) disable iff (!rst_n)
    (in_valid && !known_op) |=> (out_result == $past(in_old)));

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_chk_half
    a_r5_one_lane_per_half: assert property (
      @(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(hw_diff[h*H_LANES +: H_LANES]) <= 1));
  end

endmodule

bind vneg_index_unit vni_unit_chk #(
  .VEC_W  (VEC_W),
  .HALF_W (HALF_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .in_valid   (in_valid),
  .in_opcode  (in_opcode),
  .in_old     (in_old),
  .out_valid  (out_valid),
  .out_result (out_result)
);

// File: tb/vneg_index_unit_bench.sv
module vneg_index_unit_bench;

  localparam int CLK_PERIOD = 10;

  localparam logic [16:0] C_REG_B = 17'b0111_01010010_10110;
  localparam logic [16:0] C_REG_H = 17'b0111_01010010_10111;
  localparam logic [16:0] C_IMM_B = 17'b0111_01101001_10100;
  localparam logic [16:0] C_IMM_H = 17'b0111_01101001_10101;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [16:0]  in_opcode;
  logic [255:0] in_src;
  logic [255:0] in_sel;
  logic [255:0] in_old;
  logic [4:0]   in_imm;
  logic         out_valid;
  logic [255:0] out_result;

  int n_chk;
  int n_bad;
  logic [31:0] seed;

  vneg_index_unit u_vneg_index_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_opcode  (in_opcode),
    .in_src     (in_src),
    .in_sel     (in_sel),
    .in_old     (in_old),
    .in_imm     (in_imm),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = rnd();
    return v;
  endfunction

  // Reference: per-half first sign-bit lane, merged into the chosen lane.
  function automatic logic [255:0] model(input logic [16:0] opc,
                                          input logic [255:0] s,
                                          input logic [255:0] k,
                                          input logic [255:0] o,
                                          input logic [4:0] im);
    logic [255:0] r;
    int form;
    int w;
    int lanes;
    int first;
    int slot;
    r = o;
    form = 0;
    if (opc[16:5] == 12'b011101010010 && opc[4:1] == 4'b1011) form = 1;
    else if (opc[16:5] == 12'b011101101001 && opc[4:1] == 4'b1010) form = 2;
    if (form == 0) return o;
    w = opc[0] ? 16 : 8;
    lanes = 128 / w;
    for (int h = 0; h < 2; h++) begin
      first = lanes;
      for (int i = lanes - 1; i >= 0; i--) begin
        if (s[h*128 + i*w + w - 1]) first = i;
      end
      if (form == 1) slot = int'(k[h*128 +: 4]) % lanes;
      else slot = int'(im) % lanes;
      for (int b = 0; b < w; b++) begin
        r[h*128 + slot*w + b] = (b < 5) ? first[b] : 1'b0;
      end
    end
    return r;
  endfunction

  // Lanes below p: sign clear; lane p: sign set; above p: random.
  task automatic make_src(input int w, input int plo, input int phi,
                          output logic [255:0] s);
    int lanes;
    int p;
    logic [31:0] v;
    lanes = 128 / w;
    s = '0;
    for (int h = 0; h < 2; h++) begin
      p = (h == 0) ? plo : phi;
      for (int i = 0; i < lanes; i++) begin
        v = rnd();
        if (i < p) v[w-1] = 1'b0;
        if (i == p) v[w-1] = 1'b1;
        for (int b = 0; b < w; b++) s[h*128 + i*w + b] = v[b];
      end
    end
  endtask

  task automatic chk(input logic ok, input string tag,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [16:0] opc, input logic [255:0] s,
                       input logic [255:0] k, input logic [255:0] o,
                       input logic [4:0] im);
    in_opcode = opc;
    in_src    = s;
    in_sel    = k;
    in_old    = o;
    in_imm    = im;
    in_valid  = 1'b1;
  endtask

  task automatic run_op(input logic [16:0] opc, input logic [255:0] s,
                        input logic [255:0] k, input logic [255:0] o,
                        input logic [4:0] im, input string tag);
    logic [255:0] exp;
    @(negedge clk);
    drive(opc, s, k, o, im);
    exp = model(opc, s, k, o, im);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, {tag, " R8 valid"}, 256'(out_valid), 256'(1));
    chk(out_result == exp, tag, out_result, exp);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 single pulse", 256'(out_valid), 256'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [16:0]  codes [4];
    logic [255:0] s;
    logic [255:0] k;
    logic [255:0] o;
    logic [255:0] s2;
    logic [255:0] k2;
    logic [255:0] o2;
    logic [255:0] e1;
    logic [255:0] e2;
    string tag;
    n_chk = 0;
    n_bad = 0;
    seed = 32'h1bad_5eed;
    codes[0] = C_REG_B;
    codes[1] = C_REG_H;
    codes[2] = C_IMM_B;
    codes[3] = C_IMM_H;

    rst_n = 1'b0;
    in_valid = 1'b0;
    in_opcode = '0;
    in_src = '0;
    in_sel = '0;
    in_old = '0;
    in_imm = '0;
    repeat (2) @(negedge clk);
    in_valid = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset holds valid low", 256'(out_valid), 256'(0));
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R8 idle after reset", 256'(out_valid), 256'(0));

    // Sweep: first-negative position x target lane / immediate, all forms (R6).
    for (int op = 0; op < 4; op++) begin
      int w;
      int lanes;
      int tmax;
      w = (op % 2 == 1) ? 16 : 8;
      lanes = 128 / w;
      tmax = (op >= 2) ? 32 : 16;
      for (int p = 0; p <= lanes; p++) begin
        for (int t = 0; t < tmax; t++) begin
          make_src(w, p, (p * 7 + 3) % (lanes + 1), s);
          k = rnd256();
          k[3:0] = 4'(t);
          k[131:128] = 4'((t + 5) % 16);
          o = rnd256();
          if (p == lanes) tag = "R2 none negative";
          else if (op >= 2) tag = "R4 immediate lane";
          else tag = "R3 register lane";
          tag = $sformatf("%s R1 R5 R6 R7 op=%0d p=%0d t=%0d", tag, op, p, t);
          run_op(codes[op], s, k, o, 5'(t), tag);
        end
      end
    end

    // Opcodes next to the valid ones must pass the old value through.
    run_op(17'h00000, rnd256(), rnd256(), rnd256(), 5'd3, "R9 zero opcode");
    run_op({12'b011101010010, 5'b10101}, rnd256(), rnd256(), rnd256(), 5'd1, "R9 reg major imm sub");
    run_op({12'b011101101001, 5'b10110}, rnd256(), rnd256(), rnd256(), 5'd7, "R9 imm major reg sub");
    run_op(17'h1ffff, rnd256(), rnd256(), rnd256(), 5'd9, "R9 all ones");

    // Back-to-back beats: each result appears one cycle after its own beat.
    make_src(8, 4, 11, s);
    k = rnd256();
    o = rnd256();
    make_src(16, 8, 0, s2);
    k2 = rnd256();
    o2 = rnd256();
    e1 = model(C_REG_B, s, k, o, 5'd0);
    e2 = model(C_IMM_H, s2, k2, o2, 5'd21);
    @(negedge clk);
    drive(C_REG_B, s, k, o, 5'd0);
    @(negedge clk);
    drive(C_IMM_H, s2, k2, o2, 5'd21);
    chk(out_valid == 1'b1, "R8 first of pair valid", 256'(out_valid), 256'(1));
    chk(out_result == e1, "R8 R3 first of pair", out_result, e1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R8 second of pair valid", 256'(out_valid), 256'(1));
    chk(out_result == e2, "R8 R4 second of pair", out_result, e2);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 pair ends", 256'(out_valid), 256'(0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule